// File: doc/BRIEF.md
# Multiplexed Address/Data Host Bus Interface

This block is the byte-wide host port of a small peripheral. Address and data share one set of eight bus lines. A select input decides what each bus cycle carries. An address cycle loads an internal pointer register. A data cycle reads or writes the location that the pointer selects.

The locations form one byte-addressed space. A window of general-purpose user RAM is held inside the block. Every other address belongs to a register file outside the block, which this interface reaches through a simple address, write-data, write-pulse and read-data connection.

Two strobe conventions are decoded by the same logic:
- Separate active-low read and write strobes.
- One active-low data strobe plus a read/write direction line.

A static strap picks the convention. A power-fail input blocks every access and keeps the bus output disabled. All bus inputs are treated as already synchronous to `clk`. The output enable is meant to drive an external tri-state pad.

Top module: `mux_bus_if`

## Requirements
- R1: After reset, the pointer is 0x00, every RAM byte is 0x00, `bus_oe` is low and `reg_wr` is low.
- R2: A write cycle with `ad_sel`=0 (address phase) loads the pointer with the captured byte. `reg_addr` shows the pointer.
- R3: A write cycle with `ad_sel`=1 (data phase) whose pointer lies in the RAM window (upper four bits equal to those of `RAM_BASE`, default 0xF0) writes RAM byte pointer[3:0]. Outside the window, such a write gives a one-cycle `reg_wr` pulse with `reg_wdata` equal to the captured byte, and leaves the RAM unchanged.
- R4: During a read, `bus_out` shows the pointer when `ad_sel`=0. When `ad_sel`=1, it shows the RAM byte for an in-window pointer, or `reg_rdata` otherwise.
- R5: `bus_oe` is high in exactly the same cycle as `cs_n` is low, the read condition of the current mode holds and `pwr_fail` is low. It drops as soon as either `cs_n` or the read strobe deactivates.
- R6: With `mode_moto`=0, a read is `rd_n`=0 with `wr_n`=1, and a write is `wr_n`=0 with `rd_n`=1. Both strobes low is no access.
- R7: With `mode_moto`=1, `rd_n` is the data strobe and `wr_n` is the direction: 1 reads, 0 writes.
- R8: The written byte and its phase are those sampled on the last clock edge at which the write was active. The write takes effect on the first edge at which it is no longer active, whether `cs_n` or the strobe ended it.
- R9: While `pwr_fail` is high, `bus_oe` stays low, the pointer and RAM do not change and `reg_wr` stays low. A write cut off by `pwr_fail` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_moto | input | 1 | Static strap: 0 = read/write strobes, 1 = data strobe plus direction |
| pwr_fail | input | 1 | Power-fail; blocks all accesses |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Read strobe, or data strobe in mode 1 |
| wr_n | input | 1 | Write strobe, or direction (1 read, 0 write) in mode 1 |
| ad_sel | input | 1 | 0 = address cycle, 1 = data cycle |
| bus_in | input | DW | Bus value seen at the pads |
| bus_out | output | DW | Read data for the pads |
| bus_oe | output | 1 | Pad output enable |
| reg_addr | output | DW | Register file address (pointer) |
| reg_wdata | output | DW | Register file write data |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_rdata | input | DW | Register file read data |

## Verification
The bench builds the block with its defaults:
- 8-bit bus.
- 16-byte RAM at base 0xF0.
- `MODE_SEL`=0, so the strap pin picks the decoding at run time.

With these settings, both strobe conventions can be exercised in one run. They are switched only between cycles. Random pointers land both inside and outside the RAM window, so the window edges 0xEF, 0xF0 and 0xFF are within reach. Directed cases cover:
- writes ended by chip select and writes ended by the strobe;
- both strobes low at once;
- power-fail held across a whole cycle;
- power-fail rising in the middle of a write.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
   // Strobe decoding variants selected at elaboration
   typedef enum int {
      MBI_MODE_STRAP = 0,   // strap pin picks at run time
      MBI_MODE_SEP   = 1,   // separate read/write strobes only
      MBI_MODE_DSRW  = 2    // data strobe plus direction only
   } mbi_mode_e;
endpackage

// File: rtl/mbi_strobe_dec.sv
module mbi_strobe_dec
   import mbi_pkg::*;
#(
   parameter int MODE_SEL = MBI_MODE_STRAP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mode_moto,
   input  logic pwr_fail,
   input  logic cs_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_act,
   output logic wr_act
);
   logic sep_rd, sep_wr, dsrw_rd, dsrw_wr;
   logic raw_rd, raw_wr;

   assign sep_rd  = ~rd_n &  wr_n;
   assign sep_wr  = ~wr_n &  rd_n;
   assign dsrw_rd = ~rd_n &  wr_n;
   assign dsrw_wr = ~rd_n & ~wr_n;

   generate
      if (MODE_SEL == MBI_MODE_SEP) begin : g_sep
         assign raw_rd = sep_rd;
         assign raw_wr = sep_wr;
      end else if (MODE_SEL == MBI_MODE_DSRW) begin : g_dsrw
         assign raw_rd = dsrw_rd;
         assign raw_wr = dsrw_wr;
      end else begin : g_strap
         assign raw_rd = mode_moto ? dsrw_rd : sep_rd;
         assign raw_wr = mode_moto ? dsrw_wr : sep_wr;
      end
   endgenerate

   assign rd_act = ~pwr_fail & ~cs_n & raw_rd;
   assign wr_act = ~pwr_fail & ~cs_n & raw_wr;

   initial begin
      if (MODE_SEL < 0 || MODE_SEL > 2)
         $error("mbi_strobe_dec: MODE_SEL out of range");
   end

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_act && wr_act)); // R6
   AST_NO_ACT_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !(rd_act || wr_act)); // R5
endmodule

// File: rtl/mbi_user_ram.sv
module mbi_user_ram #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] word_q [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q[g] <= '0;
            else if (we && (idx == IW'(g)))
               word_q[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = word_q[idx];

   initial begin
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0)
         $error("mbi_user_ram: DEPTH must be a power of two");
   end

   AST_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(rdata) || !$stable(idx)); // R9
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
   import mbi_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          RAM_DEPTH = 16,
   parameter logic [7:0]  RAM_BASE  = 8'hF0,
   parameter int          MODE_SEL  = MBI_MODE_STRAP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_moto,
   input  logic          pwr_fail,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic          ad_sel,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   output logic [DW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          reg_wr,
   input  logic [DW-1:0] reg_rdata
);
   localparam int          IW       = $clog2(RAM_DEPTH);
   localparam logic [DW-1:0] WIN_MASK = ~(DW'(RAM_DEPTH - 1));
   localparam logic [DW-1:0] BASE_DW  = DW'(RAM_BASE);

   logic          rd_act, wr_act;
   logic          wr_q, cap_ad;
   logic [DW-1:0] cap_data, ptr_q, ram_rd;
   logic          commit, in_win, ram_we;

   mbi_strobe_dec #(.MODE_SEL(MODE_SEL)) u_dec (
      .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .pwr_fail(pwr_fail),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rd_act(rd_act), .wr_act(wr_act)
   );

   // Capture bus value and phase on every edge the write is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q     <= 1'b0;
         cap_ad   <= 1'b0;
         cap_data <= '0;
      end else begin
         wr_q <= wr_act;
         if (wr_act) begin
            cap_ad   <= ad_sel;
            cap_data <= bus_in;
         end
      end
   end

   assign commit = wr_q & ~wr_act & ~pwr_fail;
   assign in_win = (ptr_q & WIN_MASK) == (BASE_DW & WIN_MASK);
   assign ram_we = commit & cap_ad & in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         reg_wr    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_wr <= commit & cap_ad & ~in_win;
         if (commit & ~cap_ad)
            ptr_q <= cap_data;
         if (commit & cap_ad & ~in_win)
            reg_wdata <= cap_data;
      end
   end

   mbi_user_ram #(.DW(DW), .DEPTH(RAM_DEPTH)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ptr_q[IW-1:0]),
      .wdata(cap_data), .rdata(ram_rd)
   );

   assign reg_addr = ptr_q;
   assign bus_oe   = rd_act;
   assign bus_out  = !ad_sel ? ptr_q : (in_win ? ram_rd : reg_rdata);

   initial begin
      if (DW < IW + 1 || DW > 8)
         $error("mux_bus_if: DW must hold the RAM index and fit the base");
      if ((RAM_BASE & 8'(RAM_DEPTH - 1)) != 8'h00)
         $error("mux_bus_if: RAM_BASE must be aligned to RAM_DEPTH");
   end

   AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (!cs_n && !pwr_fail)); // R5
   AST_PF_NO_REGWR: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> !reg_wr); // R9
   AST_PF_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> $stable(reg_addr)); // R9
   AST_REGWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr); // R3
   AST_PTR_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_q |=> $stable(reg_addr)); // R8
endmodule

// File: tb/mux_bus_if_test.sv
`timescale 1ns/1ps
module mux_bus_if_test;
   logic       clk = 0, rst_n = 0;
   logic       mode_moto = 0, pwr_fail = 0, cs_n = 1, rd_n = 1, wr_n = 1, ad_sel = 0;
   logic [7:0] bus_in = 0, bus_out, reg_addr, reg_wdata, reg_rdata;
   logic       bus_oe, reg_wr;
   int         n_chk = 0, n_fail = 0;

   logic [7:0] m_ptr;
   logic [7:0] m_ram [16];

   always #4 clk = ~clk;   // 125 MHz

   assign reg_rdata = reg_addr ^ 8'h5A;

   mux_bus_if uut (
      .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .pwr_fail(pwr_fail),
      .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ad_sel(ad_sel), .bus_in(bus_in),
      .bus_out(bus_out), .bus_oe(bus_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
   );

   function automatic logic win(input logic [7:0] p);
      return p[7:4] == 4'hF;
   endfunction

   function automatic logic [7:0] exp_read(input logic ad, input logic [7:0] p);
      if (!ad) return p;
      return win(p) ? m_ram[p[3:0]] : (p ^ 8'h5A);
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic idle();
      cs_n = 1; rd_n = 1; wr_n = 1;
   endtask

   // end_by: 0 = strobe released, 1 = chip select released
   task automatic bus_write(input logic ad, input logic [7:0] d, input logic end_by);
      @(negedge clk);
      ad_sel = ad; bus_in = ~d; cs_n = 0;
      if (mode_moto) begin wr_n = 0; rd_n = 0; end
      else           begin wr_n = 0; rd_n = 1; end
      @(negedge clk);
      bus_in = d;                         // last value wins (R8)
      @(negedge clk);
      if (end_by) cs_n = 1;
      else if (mode_moto) rd_n = 1;
      else wr_n = 1;
      bus_in = 8'h00; ad_sel = ~ad;       // after end: must be ignored (R8)
      @(negedge clk);                     // commit edge has passed
      if (ad) begin
         if (win(m_ptr)) begin
            m_ram[m_ptr[3:0]] = d;
            check("R3 no reg_wr in window", {7'd0, reg_wr}, 8'd0);
         end else begin
            check("R3 reg_wr pulse", {7'd0, reg_wr}, 8'd1);
            check("R3 reg_wdata", reg_wdata, d);
         end
      end else begin
         m_ptr = d;
         check("R2 pointer load", reg_addr, d);
      end
      idle();
      @(negedge clk);
      check("R3 reg_wr single cycle", {7'd0, reg_wr}, 8'd0);
   endtask

   task automatic bus_read(input logic ad, input string req);
      @(negedge clk);
      ad_sel = ad; cs_n = 0;
      if (mode_moto) begin wr_n = 1; rd_n = 0; end
      else           begin wr_n = 1; rd_n = 0; end
      #1;
      check("R5 oe during read", {7'd0, bus_oe}, 8'd1);
      check(req, bus_out, exp_read(ad, m_ptr));
      @(negedge clk);
      rd_n = 1; #1;
      check("R5 oe off after strobe", {7'd0, bus_oe}, 8'd0);
      idle();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h1234));
      m_ptr = 0;
      for (int i = 0; i < 16; i++) m_ram[i] = 8'h00;
      repeat (3) @(negedge clk);
      check("R1 oe reset", {7'd0, bus_oe}, 8'd0);
      check("R1 reg_wr reset", {7'd0, reg_wr}, 8'd0);
      check("R1 pointer reset", reg_addr, 8'h00);
      rst_n = 1;

      for (int i = 0; i < 16; i++) begin
         bus_write(0, 8'hF0 + 8'(i), 0);
         bus_read(1, "R1 RAM reset value");
      end

      // R6: both strobes low in mode 0 is no access
      bus_write(0, 8'h33, 0);
      @(negedge clk);
      cs_n = 0; rd_n = 0; wr_n = 0; ad_sel = 0; bus_in = 8'h99; #1;
      check("R6 both low no oe", {7'd0, bus_oe}, 8'd0);
      repeat (2) @(negedge clk);
      idle();
      @(negedge clk);
      check("R6 both low no write", reg_addr, 8'h33);

      // R7: in mode 1, wr_n=1 with strobe is a read
      mode_moto = 1;
      bus_read(0, "R7 direction read pointer");
      bus_write(0, 8'hF5, 1);
      bus_write(1, 8'hC3, 0);
      bus_read(1, "R7 RAM read back");
      mode_moto = 0;

      // Window edges
      bus_write(0, 8'hEF, 1); bus_write(1, 8'h11, 0); bus_read(1, "R4 reg read at EF");
      bus_write(0, 8'hFF, 0); bus_write(1, 8'h22, 1); bus_read(1, "R4 RAM read at FF");
      bus_write(0, 8'hF0, 0); bus_write(1, 8'h44, 0); bus_read(1, "R3 RAM write at F0");

      // R9: power-fail held across a read and a write
      pwr_fail = 1;
      @(negedge clk);
      cs_n = 0; rd_n = 0; ad_sel = 1; #1;
      check("R9 oe low in power fail", {7'd0, bus_oe}, 8'd0);
      idle();
      @(negedge clk);
      cs_n = 0; wr_n = 0; ad_sel = 0; bus_in = 8'h01;
      repeat (2) @(negedge clk);
      idle();
      repeat (2) @(negedge clk);
      check("R9 pointer unchanged", reg_addr, 8'hF0);
      pwr_fail = 0;

      // R9: power-fail rising mid-write drops the write
      @(negedge clk);
      cs_n = 0; wr_n = 0; ad_sel = 1; bus_in = 8'hEE;
      @(negedge clk);
      pwr_fail = 1;
      @(negedge clk);
      idle();
      @(negedge clk);
      pwr_fail = 0;
      @(negedge clk);
      bus_read(1, "R9 aborted write dropped");

      // Random mix
      for (int i = 0; i < 300; i++) begin
         logic [7:0] p;
         mode_moto = 1'($urandom());
         p = ($urandom() % 2) ? (8'hF0 | 8'($urandom() % 16)) : 8'($urandom());
         bus_write(0, p, 1'($urandom()));
         case ($urandom() % 3)
            0: bus_write(1, 8'($urandom()), 1'($urandom()));
            1: bus_read(1, "R4 random data read");
            default: bus_read(0, "R4 random pointer read");
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule